// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull Control

This block is an eight-pin general-purpose I/O port attached to a small CPU register bus. Software sets each pin's direction and output level, and reads back the state of the pins. A third register turns on the pad's pull devices. That register is write-only and its bits are active-low: a 0 turns a pull on and a 1 turns it off. For every pin the block drives four pad controls: output enable, output level, pull-up enable and pull-down enable.

A static configuration input gives each pin a pull-up device, a pull-down device or no pull device. The two kinds of pull follow different rules. A pull-up stays on whatever the pin's direction. A pull-down is applied only while the pin is an input. Reset clears the direction register and the pull register, so every pin starts as an input with its fitted pull device active. Pad inputs pass through a two-flop synchronizer before any read sees them. Reset is asserted asynchronously and released on the clock.

Top module: `gpio_pull_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0x00), `pad_out` = 0x00, and each pin's fitted pull device is active.
- R2: A bus write to address 1 loads the direction register. A direction bit of 1 makes that pin an output (`pad_oe` bit high), and the pin then drives the data register bit on `pad_out`.
- R3: A bus read of address 0 returns, for each bit, the data register bit where the pin is an output and the synchronized pad value where the pin is an input. `bus_rdata` is registered and is valid after the clock edge on which `bus_rd` is high.
- R4: A pin configured for a pull-up (`pull_cfg` field 2'b01) has `pad_pu_en` high whenever its pull register bit is 0, in either direction.
- R5: A pin configured for a pull-down (`pull_cfg` field 2'b10) has `pad_pd_en` high only when its pull register bit is 0 and the pin is an input.
- R6: A pull register bit of 1 (written at address 2), or a `pull_cfg` field of 2'b00 or 2'b11, turns both pull enables of that pin off.
- R7: A read of address 2 (the write-only pull register) returns 0x00.
- R8: A pad value reaches `bus_rdata` on the third rising edge after it is applied. A read that captures on the second edge still returns the old value.
- R9: A write to address 3 changes no register and no pad control, and a read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 pull (active-low) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pad input levels |
| pull_cfg | input | 16 | Static pull option, 2 bits per pin at [2i+1:2i]: 01 up, 10 down, 00/11 none |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu_en | output | 8 | Per-pin pull-up enable |
| pad_pd_en | output | 8 | Per-pin pull-down enable |

## Verification
The configuration is fixed so that the eight pins cover pull-up, pull-down, none coded 00 and none coded 11. A vector table then sweeps the direction, pull and data registers and the pad levels through all-input, all-output, nibble-split and checkerboard patterns. Mixed directions separate the pull-down's dependence on direction from the pull-up's independence of it. Mixed read-back separates the latched output bits from the sampled input bits. Directed tests cover the reset state, the zero read of the pull register, the unmapped address, and the exact edge at which a pad change becomes readable.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PULLN = 2'd2;

  typedef enum logic [1:0] {
    PULL_NONE     = 2'b00,
    PULL_UP       = 2'b01,
    PULL_DOWN     = 2'b10,
    PULL_NONE_ALT = 2'b11
  } pull_opt_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb chain_d = {chain_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= 2'b00;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q, stage2_q;
  logic [WIDTH-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = d;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign q = stage2_q;

  // R8: the second stage always trails the first by exactly one cycle
  a_r8_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage2_q == $past(stage1_q))
    else $error("a_r8_stage_shift");
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  pulln_o
);
  logic [WIDTH-1:0] data_q, dir_q, pulln_q, rdata_q;
  logic [WIDTH-1:0] rdata_d;
  logic             data_en, dir_en, pulln_en;

  always_comb begin
    data_en  = wr && (addr == ADDR_DATA);
    dir_en   = wr && (addr == ADDR_DIR);
    pulln_en = wr && (addr == ADDR_PULLN);
    unique case (addr)
      ADDR_DATA: rdata_d = (dir_q & data_q) | (~dir_q & pin_sync);
      ADDR_DIR:  rdata_d = dir_q;
      default:   rdata_d = '0;  // pull register is write-only; unmapped reads zero
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      pulln_q <= '0;
      rdata_q <= '0;
    end else begin
      if (data_en)  data_q  <= wdata;
      if (dir_en)   dir_q   <= wdata;
      if (pulln_en) pulln_q <= wdata;
      if (rd)       rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign dir_o   = dir_q;
  assign data_o  = data_q;
  assign pulln_o = pulln_q;

  // R2: a direction write lands in the next cycle
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_DIR) |=> dir_q == $past(wdata))
    else $error("a_r2_dir_load");

  // R7: reading the pull register yields zero
  a_r7_pull_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == ADDR_PULLN) |=> rdata_q == '0)
    else $error("a_r7_pull_read_zero");

  // R9: a write to the unmapped address leaves all registers alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd3) |=> $stable(dir_q) && $stable(data_q) && $stable(pulln_q))
    else $error("a_r9_unmapped_write");
endmodule

// File: rtl/gpio_pull_ctrl.sv
module gpio_pull_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CFG_W = 2 * WIDTH
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] pulln,
  output logic [WIDTH-1:0] pu_en,
  output logic [WIDTH-1:0] pd_en
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pull_opt_e opt;
    assign opt = pull_opt_e'(cfg[2*i +: 2]);

    always_comb begin
      pu_en[i] = (opt == PULL_UP)   && !pulln[i];
      pd_en[i] = (opt == PULL_DOWN) && !pulln[i] && !dir[i];
    end

    always_comb begin
      // R6: a set pull bit silences both devices
      if (pulln[i] == 1'b1)
        a_r6_off_when_set: assert (!pu_en[i] && !pd_en[i])
          else $error("a_r6_off_when_set");
      // R5: an output pin never has its pull-down on
      if (dir[i] == 1'b1)
        a_r5_pd_input_only: assert (!pd_en[i])
          else $error("a_r5_pd_input_only");
    end
  end
endmodule

// File: rtl/gpio_pull_port.sv
module gpio_pull_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CFG_W = 2 * WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  input  logic [CFG_W-1:0]  pull_cfg,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu_en,
  output logic [WIDTH-1:0]  pad_pd_en
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] pin_sync, dir_w, data_w, pulln_w;

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_regfile #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .dir_o    (dir_w),
    .data_o   (data_w),
    .pulln_o  (pulln_w)
  );

  gpio_pull_ctrl #(.WIDTH(WIDTH)) u_pull (
    .cfg   (pull_cfg),
    .dir   (dir_w),
    .pulln (pulln_w),
    .pu_en (pad_pu_en),
    .pd_en (pad_pd_en)
  );

  assign pad_oe  = dir_w;
  assign pad_out = data_w;

  // R4: a pull-up never drops because of a direction write alone
  a_r4_pu_dir_free: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_DIR && $stable(pulln_w)) |=> $stable(pad_pu_en))
    else $error("a_r4_pu_dir_free");
endmodule

// File: tb/gpio_pull_port_test.sv
module gpio_pull_port_test;
  localparam int W = 8;
  localparam logic [15:0] CFG = 16'h78A5; // pins 0,1,7 up; 2,3,5 down; 4 none(00); 6 none(11)

  typedef struct packed {
    logic [7:0] dir;
    logic [7:0] pulln;
    logic [7:0] data;
    logic [7:0] pad;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'hFF, 8'hA5},
    '{8'hFF, 8'h00, 8'h3C, 8'h00},
    '{8'h0F, 8'hF0, 8'hAA, 8'h55},
    '{8'hF0, 8'h0F, 8'h55, 8'hFF},
    '{8'hFF, 8'hFF, 8'h81, 8'h7E},
    '{8'h00, 8'hFF, 8'h00, 8'hC3},
    '{8'hA5, 8'h5A, 8'hF0, 8'h0F},
    '{8'h24, 8'h00, 8'hDB, 8'h99}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, pad_in;
  logic [15:0] pull_cfg;
  logic [7:0] pad_oe, pad_out, pad_pu_en, pad_pd_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gpio_pull_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pull_cfg(pull_cfg), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en)
  );

  function automatic logic [7:0] exp_pu(input logic [7:0] pulln);
    logic [7:0] r;
    for (int i = 0; i < W; i++) r[i] = (CFG[2*i +: 2] == 2'b01) && !pulln[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_pd(input logic [7:0] pulln, input logic [7:0] dir);
    logic [7:0] r;
    for (int i = 0; i < W; i++) r[i] = (CFG[2*i +: 2] == 2'b10) && !pulln[i] && !dir[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; pad_in = 8'h5A; pull_cfg = CFG;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    check("R1 pu", pad_pu_en, 8'h83);
    check("R1 pd", pad_pd_en, 8'h2C);
    bus_read(2'd0, rv);
    check("R1 R3 input read", rv, 8'h5A);

    // vector table: R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      bus_write(2'd1, VECS[k].dir);
      bus_write(2'd2, VECS[k].pulln);
      bus_write(2'd0, VECS[k].data);
      pad_in = VECS[k].pad;
      settle();
      check("R2 oe", pad_oe, VECS[k].dir);
      check("R2 out", pad_out, VECS[k].data);
      check("R4 R6 pu", pad_pu_en, exp_pu(VECS[k].pulln));
      check("R5 R6 pd", pad_pd_en, exp_pd(VECS[k].pulln, VECS[k].dir));
      bus_read(2'd0, rv);
      check("R3 data read", rv,
            (VECS[k].dir & VECS[k].data) | (~VECS[k].dir & VECS[k].pad));
    end

    // R7 pull register read returns zero (register holds 0x00 from last vector; load nonzero)
    bus_write(2'd2, 8'hC3);
    bus_read(2'd2, rv);
    check("R7 pull read", rv, 8'h00);

    // R9 unmapped address
    bus_write(2'd1, 8'h0F);
    bus_write(2'd0, 8'h96);
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'hFF);
    settle();
    check("R9 oe kept", pad_oe, 8'h0F);
    check("R9 out kept", pad_out, 8'h96);
    check("R9 pu kept", pad_pu_en, exp_pu(8'h00));
    check("R9 pd kept", pad_pd_en, exp_pd(8'h00, 8'h0F));
    bus_read(2'd3, rv);
    check("R9 unmapped read", rv, 8'h00);

    // R8 synchronizer latency
    bus_write(2'd1, 8'h00);
    pad_in = 8'h11;
    settle();
    @(negedge clk);
    pad_in = 8'hEE; bus_addr = 2'd0; bus_rd = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 second edge old", bus_rdata, 8'h11);
    @(negedge clk);
    check("R8 third edge new", bus_rdata, 8'hEE);
    bus_rd = 1'b0;

    // R1 second reset mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async oe", pad_oe, 8'h00);
    rst_n = 1'b1;
    settle();
    check("R1 re-reset pu", pad_pu_en, 8'h83);
    check("R1 re-reset pd", pad_pd_en, 8'h2C);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule